// File: doc/BRIEF.md
# Speed-Aware ROM Cycle Acknowledge Generator

This block produces the bus-sizing acknowledge that a 32-bit CPU receives when it reads a slow flash ROM. It counts how long the active-low address strobe has been asserted. To do this it shifts the asserted level into a short delay line that advances on every CPU clock. It then chooses one tap of that line as the point at which the ROM cycle may end.

Which tap is used depends on the system speed. Low-speed operation ends the cycle early. High-speed operation waits four CPU cycles, which is 80 ns at 50 MHz. A strap adds one more cycle in high-speed mode for flash parts on a heavily loaded data bus.

The acknowledge is a two-bit active-low vector. Only its upper bit ever asserts, so every completed ROM cycle reports a 16-bit port. It asserts only while the current cycle has been decoded as a ROM access. The speed flag and the strap are captured only between cycles. A mode change during an access therefore cannot shorten that access.

Top module: `rom_ack_gen`

## Requirements
- R1: While `rst_n` is low, `ack_n` reads 2'b11 at any strobe, select or mode input.
- R2: In high-speed mode (captured `low_speed`=0, `extend_wait`=0), during a ROM cycle `ack_n[1]` is 1 after the first 4 rising clock edges with `as_n` low, and 0 from the 5th edge on.
- R3: In low-speed mode (captured `low_speed`=1), during a ROM cycle `ack_n[1]` is 1 right after `as_n` falls and after the 1st edge, and 0 from the 2nd edge on.
- R4: In high-speed mode with captured `extend_wait`=1, `ack_n[1]` first reads 0 after the 6th edge with `as_n` low.
- R5: In low-speed mode, `extend_wait` has no effect: the acknowledge still first reads 0 after the 2nd edge.
- R6: `ack_n[0]` is 1 at all times, so a completed ROM cycle always signals a 16-bit port.
- R7: While `rom_sel` is 0, `ack_n[1]` is 1 however long `as_n` stays low.
- R8: `ack_n[1]` returns to 1 as soon as `as_n` goes high, in the same cycle. One rising edge with `as_n` high clears the count, so the next strobe again waits the full tap count.
- R9: `low_speed` and `extend_wait` are captured only on rising edges where `as_n` is high. A change while `as_n` is low does not alter the delay of the running cycle.
- R10: After reset, the captured mode is low-speed without extension until the first edge with `as_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; the delay line advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | CPU address strobe, active low |
| rom_sel | input | 1 | High when the current cycle is decoded as a ROM access |
| low_speed | input | 1 | High when the system runs in low-speed mode |
| extend_wait | input | 1 | Strap: add one wait cycle in high-speed mode |
| ack_n | output | 2 | Active-low acknowledge; bit 1 ends the cycle, bit 0 is held at 1 |

## Verification
Each result has a fixed due time. The acknowledge falls only after the selected number of rising edges has passed with the strobe low: 2 in low-speed mode, 5 in high-speed mode and 6 with the strap. It rises combinationally in the same cycle the strobe negates. The bench drives the inputs on falling edges and compares `ack_n` at every falling edge from the strobe's fall through the eighth edge, so it sees both the cycle before assertion and the cycle of assertion. Mode inputs are settled two edges before each strobe, so they are captured. The mid-cycle mode changes are made only after the strobe is already low.

// File: rtl/rom_ack_pkg.sv
// Shared types for the ROM acknowledge generator.
// Assumes: nothing beyond IEEE 1800-2017.
package rom_ack_pkg;

    // Speed settings that were captured between bus cycles.
    typedef struct packed {
        logic slow;    // 1: low-speed tap in use
        logic extend;  // 1: one extra wait cycle in high-speed mode
    } speed_mode_t;

    // Mode in force directly after reset.
    localparam speed_mode_t MODE_AT_RESET = '{slow: 1'b1, extend: 1'b0};

endpackage

// File: rtl/strobe_delay_line.sv
// Strobe delay line: shifts the asserted address strobe in once per clock.
// Tap i reads 1 once the strobe has been low for at least i+1 rising edges.
// Assumes: as_n is synchronous to clk. The line empties on the first edge
// that sees the strobe negated.
module strobe_delay_line #(
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    output logic [DEPTH-1:0] taps
);

    logic [DEPTH-1:0] stage_q;

    // Stage 0 records the first asserted edge; it empties when the strobe negates.
    always_ff @(posedge clk) begin
        if (!rst_n || as_n) stage_q[0] <= 1'b0;
        else                stage_q[0] <= 1'b1;
    end

    // Later stages: each one follows its predecessor while the strobe stays low.
    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n || as_n) stage_q[g] <= 1'b0;
                else                stage_q[g] <= stage_q[g-1];
            end

            // A later tap never leads an earlier one (timing of R2 rests on it).
            assert_thermometer_R2: assert property (
                @(posedge clk) disable iff (!rst_n) stage_q[g] |-> stage_q[g-1]
            );
        end
    endgenerate

    assign taps = stage_q;

endmodule

// File: rtl/speed_mode_latch.sv
// Speed mode latch: captures the speed flag and the extend strap between
// bus cycles only, so that an access in progress keeps its delay.
// Assumes: low_speed and extend_wait are synchronous to clk.
module speed_mode_latch
    import rom_ack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        as_n,
    input  logic        low_speed,
    input  logic        extend_wait,
    output speed_mode_t mode
);

    speed_mode_t mode_q;

    // Capture the mode inputs only while the strobe is negated.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= MODE_AT_RESET;
        else if (as_n) mode_q <= '{slow: low_speed, extend: extend_wait};
    end

    // The mode stays fixed across every edge that sees the strobe asserted.
    assert_mode_hold_R9: assert property (
        @(posedge clk) disable iff (!rst_n) !as_n |=> $stable(mode_q)
    );

    assign mode = mode_q;

endmodule

// File: rtl/ack_tap_select.sv
// Acknowledge selection: picks the delay tap for the captured speed mode and
// gates the result with the ROM select and the live strobe.
// Assumes: SLOW_TAP and EXT_TAP both lie below DEPTH.
module ack_tap_select
    import rom_ack_pkg::*;
#(
    parameter int DEPTH    = 6,
    parameter int SLOW_TAP = 1,
    parameter int FAST_TAP = 4,
    parameter int EXT_TAP  = 5
) (
    input  logic [DEPTH-1:0] taps,
    input  speed_mode_t      mode,
    input  logic             as_n,
    input  logic             rom_sel,
    output logic [1:0]       ack_n
);

    logic fast_ready;
    logic tap_ready;

    // High-speed tap: the extended tap when the strap was captured.
    always_comb begin
        fast_ready = mode.extend ? taps[EXT_TAP] : taps[FAST_TAP];
    end

    // Pick the low-speed or high-speed tap.
    always_comb begin
        tap_ready = mode.slow ? taps[SLOW_TAP] : fast_ready;
    end

    // Drive the acknowledge: upper bit only for a live ROM cycle, lower bit idle.
    always_comb begin
        ack_n[1] = ~(tap_ready & rom_sel & ~as_n);
        ack_n[0] = 1'b1;
    end

endmodule

// File: rtl/rom_ack_gen.sv
// ROM cycle acknowledge generator (top level).
// Delays the address strobe, chooses a tap by speed mode and answers ROM
// cycles with an active-low 16-bit-port acknowledge.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module rom_ack_gen
    import rom_ack_pkg::*;
#(
    parameter int SLOW_TAP = 1,
    parameter int FAST_TAP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       rom_sel,
    input  logic       low_speed,
    input  logic       extend_wait,
    output logic [1:0] ack_n
);

    localparam int EXT_TAP = FAST_TAP + 1;
    localparam int DEPTH   = (EXT_TAP > SLOW_TAP) ? EXT_TAP + 1 : SLOW_TAP + 1;

    logic [DEPTH-1:0] taps;
    speed_mode_t      mode;

    strobe_delay_line #(.DEPTH(DEPTH)) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .as_n  (as_n),
        .taps  (taps)
    );

    speed_mode_latch i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n        (as_n),
        .low_speed   (low_speed),
        .extend_wait (extend_wait),
        .mode        (mode)
    );

    ack_tap_select #(
        .DEPTH    (DEPTH),
        .SLOW_TAP (SLOW_TAP),
        .FAST_TAP (FAST_TAP),
        .EXT_TAP  (EXT_TAP)
    ) i_select (
        .taps    (taps),
        .mode    (mode),
        .as_n    (as_n),
        .rom_sel (rom_sel),
        .ack_n   (ack_n)
    );

    // A non-ROM cycle never gets an acknowledge.
    assert_no_ack_non_rom_R7: assert property (
        @(posedge clk) disable iff (!rst_n) !rom_sel |-> ack_n[1]
    );

    // A negated strobe always sees the acknowledge released.
    assert_release_on_negate_R8: assert property (
        @(posedge clk) disable iff (!rst_n) as_n |-> ack_n[1]
    );

    // No acknowledge on the strobe's first edge, nor on the edge after it.
    assert_no_early_ack_R3: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(as_n) |-> ack_n[1]
    );
    assert_min_wait_R3: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(as_n) |=> ack_n[1]
    );

endmodule

// File: tb/test_rom_ack_gen.sv
// Self-checking bench for rom_ack_gen.
// Inputs are driven on falling edges, and ack_n is sampled on falling edges.
module test_rom_ack_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       as_n = 1'b1;
    logic       rom_sel = 1'b0;
    logic       low_speed = 1'b1;
    logic       extend_wait = 1'b0;
    logic [1:0] ack_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rom_ack_gen i_rom_ack_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n        (as_n),
        .rom_sel     (rom_sel),
        .low_speed   (low_speed),
        .extend_wait (extend_wait),
        .ack_n       (ack_n)
    );

    // Vector: {slow, extend, rom, first edge count with ack low (0 = never)}
    localparam logic [6:0] VECS [0:7] = '{
        {1'b0, 1'b0, 1'b1, 4'd5},   // R2
        {1'b1, 1'b0, 1'b1, 4'd2},   // R3
        {1'b0, 1'b1, 1'b1, 4'd6},   // R4
        {1'b1, 1'b1, 1'b1, 4'd2},   // R5
        {1'b0, 1'b0, 1'b0, 4'd0},   // R7
        {1'b1, 1'b0, 1'b0, 4'd0},   // R7
        {1'b0, 1'b1, 1'b0, 4'd0},   // R7
        {1'b1, 1'b1, 1'b0, 4'd0}    // R7
    };

    task automatic check(input logic [1:0] exp, input string req, input int k);
        checks++;
        if (ack_n !== exp) begin
            fails++;
            $display("FAIL %s edge %0d: ack_n=%b expected %b", req, k, ack_n, exp);
        end
    endtask

    // Settle the mode with the strobe high, run one strobe for 8 edges, then release.
    task automatic run_cycle(input logic slow, input logic ext, input logic rom,
                             input int first, input string req,
                             input bit flip_mode);
        @(negedge clk);
        as_n = 1'b1; low_speed = slow; extend_wait = ext; rom_sel = rom;
        @(negedge clk);
        @(negedge clk);
        as_n = 1'b0;
        #1 check(2'b11, req, 0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check({~(first != 0 && k >= first), 1'b1}, req, k);
            if (flip_mode && k == 1) begin
                low_speed = ~slow; extend_wait = ~ext;
            end
        end
        as_n = 1'b1;
        #1 check(2'b11, "R8", 9);
    endtask

    initial begin
        // R1: the acknowledge stays idle during reset, even with a ROM strobe present.
        rst_n = 1'b0; as_n = 1'b0; rom_sel = 1'b1; low_speed = 1'b0; extend_wait = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(2'b11, "R1", i);
        end
        // R10: the strobe is held low through release, so the reset mode (low-speed) applies.
        rst_n = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            check({~(k >= 2), 1'b1}, "R10", k);
        end
        as_n = 1'b1;
        #1 check(2'b11, "R8", 0);

        // Table walk: all speed, strap and select combinations (R2 R3 R4 R5 R6 R7).
        for (int v = 0; v < 8; v++) begin
            run_cycle(VECS[v][6], VECS[v][5], VECS[v][4], int'(VECS[v][3:0]),
                      "R2_R3_R4_R5_R6_R7", 1'b0);
        end

        // R9: a mode change after the strobe falls leaves this cycle unchanged.
        run_cycle(1'b0, 1'b0, 1'b1, 5, "R9", 1'b1);
        run_cycle(1'b1, 1'b0, 1'b1, 2, "R9", 1'b1);
        run_cycle(1'b0, 1'b1, 1'b1, 6, "R9", 1'b1);

        // R8: after one edge with the strobe high, the next strobe waits the full count.
        @(negedge clk);
        low_speed = 1'b0; extend_wait = 1'b0; rom_sel = 1'b1; as_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        as_n = 1'b0;
        for (int k = 1; k <= 6; k++) @(negedge clk);
        check(2'b01, "R8", 6);
        as_n = 1'b1;
        @(negedge clk);
        as_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check({~(k >= 5), 1'b1}, "R8", k);
        end
        as_n = 1'b1;

        // R7: dropping the select in mid-cycle releases the acknowledge.
        @(negedge clk);
        @(negedge clk);
        as_n = 1'b0;
        for (int k = 1; k <= 5; k++) @(negedge clk);
        rom_sel = 1'b0;
        #1 check(2'b11, "R7", 5);
        as_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule